// File: doc/BRIEF.md
# Bus Master Acquisition Controller

This block wins bus ownership for a DMA engine on a PCI-style multiplexed parallel bus. When the buffer-management engine asks for a transfer, it pulls the active-low request line low and waits for a usable grant from the arbiter. It then drives the address and command lines for one full clock before it asserts frame. This first-phase address stepping is used only on the first address phase of a tenure. After that phase the block hands the bus to the data-phase logic with a one-cycle `addr_issued` pulse. Any later address phase in the same tenure asserts frame at once, with no stepping clock.

A soft stop or a reset-register read ("cancel") halts the master sequencing. If the grant has not yet arrived, the request line stays low until a grant is sampled, and it is released on the edge that samples the grant. The bus lines are never driven while this release is pending. The hardware reset input works asynchronously and raises the request line at once, with no wait for a grant.

The states are IDLE, WAIT_GNT (requesting), STEP (drivers on, frame off), ADDR1 (first address phase, frame low), OWNED (tenure held by the data-phase logic), ADDRN (a later address phase) and DRAIN (cancel pending, request held until grant). The transitions are:
- IDLE→WAIT_GNT on a transfer request.
- WAIT_GNT→STEP on a usable grant.
- WAIT_GNT→DRAIN on a cancel without a grant.
- WAIT_GNT→IDLE on a cancel with a grant.
- STEP→ADDR1 when the grant is held.
- STEP→WAIT_GNT when the grant is lost.
- STEP→IDLE on a cancel.
- ADDR1→OWNED always.
- OWNED→ADDRN on a next-address request.
- OWNED→IDLE on end of tenure or on a cancel.
- ADDRN→OWNED always.
- DRAIN→IDLE on a grant.

Top module: `bus_master_acq`

## Requirements
- R1: After reset: `req_n`=1, `ad_oe`=0, `cbe_oe`=0, `frame_n`=1 and `addr_issued`=0.
- R2: If `xfer_req`=1 is sampled in idle while no cancel is present, `req_n` goes to 0 after that edge. The address and command on `xfer_addr`/`xfer_cmd` are captured on the same edge.
- R3: A grant is usable when, at a rising edge, `grant_n`=0, `frame_in_n`=1 and `irdy_in_n`=1. If a usable grant is sampled while requesting, then after that edge `ad_oe`=`cbe_oe`=1, `ad_out`/`cbe_out` hold the captured values, and `frame_n`=1.
- R4: If the grant is still low at the next edge, `frame_n`=0 with the drivers still on, `addr_issued`=1 for exactly that cycle, and `req_n`=1 from then on.
- R5: While the bus is busy (`frame_in_n`=0 or `irdy_in_n`=0), a grant is ignored and the request is held. If the grant is high at the edge that ends the stepping cycle, the drivers turn off and the request stays low.
- R6: After the first address phase the lines are released. If `next_addr`=1 is sampled in the owned tenure, the next cycle has `frame_n`=0 with the new address and command driven, no stepping cycle, and `addr_issued`=0.
- R7: If `tenure_done`=1 is sampled in the owned tenure, the block returns to idle and `req_n` stays 1.
- R8: A cancel (`soft_stop`=1 or `rst_reg_rd`=1) sampled while requesting without a grant keeps `req_n`=0 and the drivers off until `grant_n`=0 is sampled. `req_n` then goes to 1 after that edge, and no driver or frame is asserted.
- R9: If `rst_n` falls, `req_n` goes to 1 at once, without waiting for a clock edge or a grant.
- R10: `step_flag` always reads 1, reporting that address stepping is in use.
- R11: A cancel sampled at the end of the stepping cycle returns the block to idle: drivers off, `frame_n`=1 and `req_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| xfer_req | input | 1 | Transfer request from the buffer-management engine |
| xfer_addr | input | AW | Address for the address phase |
| xfer_cmd | input | CW | Bus command for the address phase |
| grant_n | input | 1 | Arbiter grant, active low |
| frame_in_n | input | 1 | Sampled bus frame, active low |
| irdy_in_n | input | 1 | Sampled bus initiator-ready, active low |
| soft_stop | input | 1 | Soft stop of the master |
| rst_reg_rd | input | 1 | Strobe for a reset-register read |
| next_addr | input | 1 | Request for a later address phase within the tenure |
| tenure_done | input | 1 | End of tenure from the data-phase logic |
| req_n | output | 1 | Bus request, active low |
| ad_oe | output | 1 | Output enable for the address/data lines |
| ad_out | output | AW | Value driven on the address/data lines |
| cbe_oe | output | 1 | Output enable for the command/byte-enable lines |
| cbe_out | output | CW | Value driven on the command lines |
| frame_n | output | 1 | Frame output, active low |
| addr_issued | output | 1 | One-cycle handoff after the first address phase |
| step_flag | output | 1 | Address-stepping status, constant 1 |

## Verification
The block's outputs decode directly from its state, so a wrong state shows up at the ports in the cycle right after the edge that caused it. A missing stepping state gives frame without a prior drive cycle. A lost DRAIN state raises the request before the grant, or turns the drivers on. A stuck ADDR1 state stretches `addr_issued`. The bench's behavioural model predicts every output on every clock under randomized grant delays and busy periods, so any of these faults is flagged within one cycle.

// File: rtl/bma_pkg.sv
package bma_pkg;
    localparam int unsigned ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        S_IDLE  = 3'd0,
        S_WAIT  = 3'd1,
        S_STEP  = 3'd2,
        S_ADDR1 = 3'd3,
        S_OWNED = 3'd4,
        S_ADDRN = 3'd5,
        S_DRAIN = 3'd6
    } acq_state_t;
endpackage

// File: rtl/bma_fsm.sv
module bma_fsm
    import bma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req,
    input  logic grant_n,
    input  logic frame_in_n,
    input  logic irdy_in_n,
    input  logic soft_stop,
    input  logic rst_reg_rd,
    input  logic next_addr,
    input  logic tenure_done,
    output logic req_n,
    output logic drive_en,
    output logic frame_n,
    output logic addr_issued,
    output logic load_first,
    output logic load_next
);
    acq_state_t st_q, st_d;
    logic cancel, gnt, usable;

    assign cancel = soft_stop | rst_reg_rd;
    assign gnt    = ~grant_n;
    assign usable = gnt & frame_in_n & irdy_in_n;

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (xfer_req && !cancel) st_d = S_WAIT;
            S_WAIT: begin
                if (cancel)      st_d = gnt ? S_IDLE : S_DRAIN;
                else if (usable) st_d = S_STEP;
            end
            S_STEP: begin
                if (cancel)       st_d = S_IDLE;
                else if (!gnt)    st_d = S_WAIT;
                else              st_d = S_ADDR1;
            end
            S_ADDR1: st_d = S_OWNED;
            S_OWNED: begin
                if (cancel || tenure_done) st_d = S_IDLE;
                else if (next_addr)        st_d = S_ADDRN;
            end
            S_ADDRN: st_d = S_OWNED;
            S_DRAIN: if (gnt) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // state register; reset is asynchronous so the request drops at once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Moore outputs
    always_comb begin
        req_n       = 1'b1;
        drive_en    = 1'b0;
        frame_n     = 1'b1;
        addr_issued = 1'b0;
        unique case (st_q)
            S_IDLE:  ;
            S_WAIT:  req_n = 1'b0;
            S_STEP: begin
                req_n    = 1'b0;
                drive_en = 1'b1;
            end
            S_ADDR1: begin
                drive_en    = 1'b1;
                frame_n     = 1'b0;
                addr_issued = 1'b1;
            end
            S_OWNED: ;
            S_ADDRN: begin
                drive_en = 1'b1;
                frame_n  = 1'b0;
            end
            S_DRAIN: req_n = 1'b0;
            default: ;
        endcase
    end

    assign load_first = (st_q == S_IDLE) && xfer_req && !cancel;
    assign load_next  = (st_q == S_OWNED) && next_addr && !cancel && !tenure_done;
endmodule

// File: rtl/bma_addr_path.sv
module bma_addr_path #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [CW-1:0] cmd_in,
    input  logic          drive_en,
    output logic          ad_oe,
    output logic [AW-1:0] ad_out,
    output logic          cbe_oe,
    output logic [CW-1:0] cbe_out
);
    localparam logic [AW-1:0] ADDR_RST = '0;
    localparam logic [CW-1:0] CMD_RST  = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ad_out  <= ADDR_RST;
            cbe_out <= CMD_RST;
        end else if (load) begin
            ad_out  <= addr_in;
            cbe_out <= cmd_in;
        end
    end

    assign ad_oe  = drive_en;
    assign cbe_oe = drive_en;
endmodule

// File: rtl/bus_master_acq.sv
module bus_master_acq #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_req,
    input  logic [AW-1:0] xfer_addr,
    input  logic [CW-1:0] xfer_cmd,
    input  logic          grant_n,
    input  logic          frame_in_n,
    input  logic          irdy_in_n,
    input  logic          soft_stop,
    input  logic          rst_reg_rd,
    input  logic          next_addr,
    input  logic          tenure_done,
    output logic          req_n,
    output logic          ad_oe,
    output logic [AW-1:0] ad_out,
    output logic          cbe_oe,
    output logic [CW-1:0] cbe_out,
    output logic          frame_n,
    output logic          addr_issued,
    output logic          step_flag
);
    logic drive_en, load_first, load_next;

    bma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .grant_n(grant_n),
        .frame_in_n(frame_in_n), .irdy_in_n(irdy_in_n), .soft_stop(soft_stop),
        .rst_reg_rd(rst_reg_rd), .next_addr(next_addr), .tenure_done(tenure_done),
        .req_n(req_n), .drive_en(drive_en), .frame_n(frame_n),
        .addr_issued(addr_issued), .load_first(load_first), .load_next(load_next)
    );

    bma_addr_path #(.AW(AW), .CW(CW)) u_path (
        .clk(clk), .rst_n(rst_n), .load(load_first | load_next),
        .addr_in(xfer_addr), .cmd_in(xfer_cmd), .drive_en(drive_en),
        .ad_oe(ad_oe), .ad_out(ad_out), .cbe_oe(cbe_oe), .cbe_out(cbe_out)
    );

    assign step_flag = 1'b1;  // R10: stepping always used on first address phase
endmodule

// File: rtl/bma_checker.sv
module bma_checker #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_req,
    input logic [AW-1:0] xfer_addr,
    input logic [CW-1:0] xfer_cmd,
    input logic          grant_n,
    input logic          frame_in_n,
    input logic          irdy_in_n,
    input logic          soft_stop,
    input logic          rst_reg_rd,
    input logic          next_addr,
    input logic          tenure_done,
    input logic          req_n,
    input logic          ad_oe,
    input logic [AW-1:0] ad_out,
    input logic          cbe_oe,
    input logic [CW-1:0] cbe_out,
    input logic          frame_n,
    input logic          addr_issued,
    input logic          step_flag
);
    // R4: a held grant with no cancel turns the stepping cycle into frame plus handoff
    a_r4_frame_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && frame_n && !grant_n && !soft_stop && !rst_reg_rd) |=> (!frame_n && addr_issued));

    // R3: frame is only asserted with address and command driven
    a_r3_frame_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> (ad_oe && cbe_oe));

    // R4: the handoff lasts a single cycle
    a_r4_issue_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        addr_issued |=> !addr_issued);

    // R4: request is released once frame goes out
    a_r4_req_off_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> req_n);

    // R8: a request without drivers is never dropped while grant is absent
    a_r8_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && !ad_oe && grant_n) |=> !req_n);

    // R6: the handoff only accompanies an asserted frame
    a_r6_issue_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        addr_issued |-> !frame_n);
endmodule

bind bus_master_acq bma_checker #(.AW(AW), .CW(CW)) i_chk (.*);

// File: tb/test_bus_master_acq.sv
module test_bus_master_acq;
    localparam int AW = 32;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_req = 0, grant_n = 1, frame_in_n = 1, irdy_in_n = 1;
    logic soft_stop = 0, rst_reg_rd = 0, next_addr = 0, tenure_done = 0;
    logic [AW-1:0] xfer_addr = '0;
    logic [CW-1:0] xfer_cmd = '0;
    logic req_n, ad_oe, cbe_oe, frame_n, addr_issued, step_flag;
    logic [AW-1:0] ad_out;
    logic [CW-1:0] cbe_out;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bus_master_acq #(.AW(AW), .CW(CW)) i_bus_master_acq (.*);

    // behavioural model: phase code 0 idle,1 asking,2 stepping,3 first addr,
    // 4 holding,5 later addr,6 releasing after cancel
    int ph = 0;
    logic [AW-1:0] e_addr = '0;
    logic [CW-1:0] e_cmd = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; e_addr = '0; e_cmd = '0;
        end else begin
            bit c, g, idle_bus;
            c = soft_stop || rst_reg_rd;
            g = !grant_n;
            idle_bus = frame_in_n && irdy_in_n;
            if (ph == 0) begin
                if (xfer_req && !c) begin ph = 1; e_addr = xfer_addr; e_cmd = xfer_cmd; end
            end else if (ph == 1) begin
                if (c) ph = g ? 0 : 6;
                else if (g && idle_bus) ph = 2;
            end else if (ph == 2) begin
                ph = c ? 0 : (g ? 3 : 1);
            end else if (ph == 3 || ph == 5) begin
                ph = 4;
            end else if (ph == 4) begin
                if (c || tenure_done) ph = 0;
                else if (next_addr) begin ph = 5; e_addr = xfer_addr; e_cmd = xfer_cmd; end
            end else if (ph == 6) begin
                if (g) ph = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit x_req, x_drv, x_frm, x_iss;
            x_req = (ph == 1 || ph == 2 || ph == 6);
            x_drv = (ph == 2 || ph == 3 || ph == 5);
            x_frm = (ph == 3 || ph == 5);
            x_iss = (ph == 3);
            chk(req_n == !x_req, "R2/R8 req_n", req_n, !x_req);
            chk(ad_oe == x_drv && cbe_oe == x_drv, "R3/R5/R11 drivers", ad_oe, x_drv);
            chk(frame_n == !x_frm, "R4/R6 frame_n", frame_n, !x_frm);
            chk(addr_issued == x_iss, "R4 addr_issued", addr_issued, x_iss);
            if (x_drv) begin
                chk(ad_out == e_addr, "R3/R6 ad_out", ad_out, e_addr);
                chk(cbe_out == e_cmd, "R3/R6 cbe_out", cbe_out, e_cmd);
            end
            chk(step_flag == 1'b1, "R10 step_flag", step_flag, 1);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic start_req();
        @(negedge clk);
        xfer_req = 1; xfer_addr = $urandom; xfer_cmd = CW'($urandom);
        @(negedge clk);
        xfer_req = 0;
    endtask

    task automatic tenure(input int gdelay, input int nlater, input bit busy);
        int steps = 0;
        start_req();
        if (busy) begin
            frame_in_n = 0; grant_n = 0;
            repeat (3) @(negedge clk);
            chk(ad_oe == 0 && req_n == 0, "R5 busy grant ignored", ad_oe, 0);
            frame_in_n = 1; grant_n = 1;
        end
        repeat (gdelay) @(negedge clk);
        grant_n = 0;
        for (int k = 0; k < 10 && frame_n; k++) begin
            @(negedge clk);
            if (ad_oe && frame_n) steps++;
        end
        grant_n = 1;
        chk(steps == 1, "R4 one stepping clock", steps, 1);
        @(negedge clk);
        for (int j = 0; j < nlater; j++) begin
            next_addr = 1; xfer_addr = $urandom; xfer_cmd = CW'($urandom);
            @(negedge clk);
            next_addr = 0;
            chk(!frame_n && ad_oe && !addr_issued, "R6 later phase no step", frame_n, 0);
            @(negedge clk);
        end
        tenure_done = 1;
        @(negedge clk);
        tenure_done = 0;
        chk(req_n == 1 && ad_oe == 0, "R7 back to idle", req_n, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(req_n == 1 && ad_oe == 0 && cbe_oe == 0 && frame_n == 1 && addr_issued == 0,
            "R1 reset outputs", {req_n, ad_oe, cbe_oe, frame_n, addr_issued}, 5'b10010);
        rst_n = 1;
        @(negedge clk);
        chk(step_flag == 1, "R10 stepping status", step_flag, 1);

        for (int i = 0; i < 30; i++) tenure($urandom_range(0, 6), $urandom_range(0, 3), (i % 4) == 1);

        // R5: grant removed during the stepping cycle
        start_req();
        grant_n = 0;
        @(negedge clk);
        chk(ad_oe == 1 && frame_n == 1, "R3 stepping drive", ad_oe, 1);
        grant_n = 1;
        @(negedge clk);
        chk(ad_oe == 0 && req_n == 0, "R5 grant lost back to asking", ad_oe, 0);
        grant_n = 0;
        repeat (2) @(negedge clk);
        grant_n = 1;
        @(negedge clk);
        tenure_done = 1; @(negedge clk); tenure_done = 0;

        // R8: soft stop and reset-register read hold request until grant
        for (int v = 0; v < 2; v++) begin
            start_req();
            if (v == 0) soft_stop = 1; else rst_reg_rd = 1;
            @(negedge clk);
            soft_stop = 0; rst_reg_rd = 0;
            repeat ($urandom_range(1, 5)) begin
                @(negedge clk);
                chk(req_n == 0 && ad_oe == 0, "R8 request held", req_n, 0);
            end
            grant_n = 0;
            @(negedge clk);
            chk(req_n == 1 && ad_oe == 0 && frame_n == 1, "R8 release after grant", req_n, 1);
            grant_n = 1;
            @(negedge clk);
        end

        // R11: cancel in the stepping cycle
        start_req();
        grant_n = 0;
        @(negedge clk);
        soft_stop = 1;
        @(negedge clk);
        soft_stop = 0; grant_n = 1;
        chk(req_n == 1 && ad_oe == 0 && frame_n == 1, "R11 cancel while stepping", req_n, 1);
        @(negedge clk);

        // R9: hardware reset drops request without a clock edge
        start_req();
        @(negedge clk);
        #2 rst_n = 0;
        #1 chk(req_n == 1, "R9 immediate release", req_n, 1);
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        tenure(2, 1, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule